// File: doc/BRIEF.md
# Character-Cell Text Pixel Generator

This block turns a raster position into a colour index for a text display made of character cells. The display timing logic supplies the current pixel column and row. The generator reads two bytes per cell from video memory: an attribute byte and a character code. It takes one row of the character's glyph and delivers one pixel per clock. Reads alternate every clock, attribute then character, so each cell is fetched again on every pixel pair. The returned bytes are held in a small register pair. This keeps the shifted-out pixels in step with the fetches.

Three configuration inputs can be set in any combination. One picks the colour scheme. In the 256-colour scheme the attribute byte is the glyph colour on a black ground. In the 16-colour scheme one nibble of the attribute is the glyph colour and the other nibble is the ground colour. The other two inputs stretch the 8x8 cell to 16 pixels wide and/or 16 pixels tall. The glyphs come from a tiny computed font inside the block.

Top module: `txt_pixel_gen`

## Requirements
- R1: `pixActive` is high exactly for input positions with `pixX < H_VIS` and `pixY < V_VIS`, delayed as in R12. While `pixActive` is low, `pixColour` is 0.
- R2: In the clock after a position is applied, `vramAddr` equals `2*cellIndex` when `pixX` is even (attribute fetch) and `2*cellIndex+1` when `pixX` is odd (character fetch), modulo 2^ADDR_W.
- R3: `cellIndex = cellRow * cellsPerRow + cellCol`. `cellCol` and `cellRow` are `pixX` and `pixY` divided by the cell width and cell height. `cellsPerRow` is `H_VIS/8`, or `H_VIS/16` when double width is set.
- R4: `vramData` is taken in the same clock in which its `vramAddr` is presented, so the memory answers combinationally to the registered address.
- R5: The glyph row `r` of character code `c` is `c` rotated left by `r` bit places. Bit 7 of that row is the leftmost pixel of the cell.
- R6: With `cfgMode16 = 0`, a set glyph pixel outputs the full attribute byte and a clear glyph pixel outputs 0.
- R7: With `cfgMode16 = 1`, a set glyph pixel outputs `attr[3:0]`, a clear glyph pixel outputs `attr[7:4]`, and bits 7:4 of `pixColour` are 0.
- R8: With `cfgDoubleW = 1`, cells are 16 pixels wide and the glyph column is the in-cell column divided by two, so pixels `2j` and `2j+1` show the same colour.
- R9: With `cfgDoubleH = 1`, cells are 16 rows tall and the glyph row is the in-cell row divided by two.
- R10: Any combination of the three configuration bits gives the result of applying each rule above together. The configuration is taken along with each pixel position.
- R11: While `rstN` is low, `vramAddr`, `pixColour` and `pixActive` are all 0.
- R12: The result for the position applied in clock n appears on `pixColour` and `pixActive` in clock n+4. This holds while `pixX` advances by one per clock from an even starting value and the line total is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixX | input | X_W | Current pixel column |
| pixY | input | Y_W | Current pixel row |
| cfgMode16 | input | 1 | 1: foreground/background nibbles; 0: 256-colour attribute |
| cfgDoubleW | input | 1 | Double cell width |
| cfgDoubleH | input | 1 | Double cell height |
| vramData | input | 8 | Byte read from video memory at `vramAddr` |
| vramAddr | output | ADDR_W | Video memory byte address |
| pixColour | output | 8 | Colour index of the output pixel |
| pixActive | output | 1 | Output pixel lies in the visible window |

## Verification
Some properties are checked on every clock by assertions. These are: black output outside the window, and the active flag matching the position four clocks earlier. Also the fetch phase carried in the address's low bit, the empty upper nibble in 16-colour mode, and equal colours across each pixel pair in double-width mode. Other behaviour depends on video memory contents and the cell arithmetic: the exact address, the font row, the choice of foreground or background, and the scaled row and column. Only full-frame scans can show these. The scans cover every configuration combination against a memory model whose expected pixels the bench computes on its own.

// File: rtl/txtgen_pkg.sv
package txtgen_pkg;

  // Per-pixel tag travelling down the control pipeline.
  typedef struct packed {
    logic       visible;
    logic       mode16;
    logic [2:0] glyphCol;
    logic [2:0] glyphRow;
  } pixTag_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic    latchAttr;
    logic    latchPair;
    pixTag_t tag;
  } ctrlStrobe_t;

  // Font: row r of code c is c rotated left by r places.
  function automatic logic [7:0] glyphRowBits(input logic [7:0] code,
                                              input logic [2:0] row);
    logic [15:0] doubled;
    doubled = {code, code} << row;
    return doubled[15:8];
  endfunction

endpackage

// File: rtl/txtgen_ctrl.sv
module txtgen_ctrl
  import txtgen_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int H_VIS  = 64,
  parameter int V_VIS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  input  logic              cfgMode16,
  input  logic              cfgDoubleW,
  input  logic              cfgDoubleH,
  output logic [ADDR_W-1:0] vramAddr,
  output ctrlStrobe_t       strobe
);

  localparam int CELLS_NARROW = H_VIS / 8;
  localparam int CELLS_WIDE   = H_VIS / 16;
  localparam int TAG_STAGES   = 3;

  logic [X_W-1:0]    cellX;
  logic [Y_W-1:0]    cellY;
  logic [ADDR_W-1:0] cellsPerRow;
  logic [ADDR_W-1:0] cellIdx;
  logic [ADDR_W-1:0] addrNext;
  pixTag_t           tagNow;
  pixTag_t           tagPipe [TAG_STAGES];
  logic              isCharPh;

  always_comb begin
    cellX       = cfgDoubleW ? (pixX >> 4) : (pixX >> 3);
    cellY       = cfgDoubleH ? (pixY >> 4) : (pixY >> 3);
    cellsPerRow = cfgDoubleW ? ADDR_W'(CELLS_WIDE) : ADDR_W'(CELLS_NARROW);
    cellIdx     = ADDR_W'(cellY) * cellsPerRow + ADDR_W'(cellX);
    addrNext    = {cellIdx[ADDR_W-2:0], pixX[0]};

    tagNow.visible  = (pixX < X_W'(H_VIS)) && (pixY < Y_W'(V_VIS));
    tagNow.mode16   = cfgMode16;
    tagNow.glyphCol = cfgDoubleW ? pixX[3:1] : pixX[2:0];
    tagNow.glyphRow = cfgDoubleH ? pixY[3:1] : pixY[2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vramAddr <= '0;
      isCharPh <= 1'b0;
      for (int s = 0; s < TAG_STAGES; s++) tagPipe[s] <= '0;
    end else begin
      vramAddr   <= addrNext;
      isCharPh   <= pixX[0];
      tagPipe[0] <= tagNow;
      for (int s = 1; s < TAG_STAGES; s++) tagPipe[s] <= tagPipe[s-1];
    end
  end

  always_comb begin
    strobe.latchAttr = !isCharPh;
    strobe.latchPair = isCharPh;
    strobe.tag       = tagPipe[TAG_STAGES-1];
  end

endmodule

// File: rtl/txtgen_datapath.sv
module txtgen_datapath
  import txtgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  vramData,
  output logic [7:0]  pixColour,
  output logic        pixActive
);

  logic [7:0] attrStage;
  logic [7:0] attrHold;
  logic [7:0] charHold;
  logic [7:0] rowBits;
  logic       pixOn;
  logic [7:0] colourNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrStage <= '0;
      attrHold  <= '0;
      charHold  <= '0;
    end else begin
      if (strobe.latchAttr) attrStage <= vramData;
      if (strobe.latchPair) begin
        attrHold <= attrStage;
        charHold <= vramData;
      end
    end
  end

  always_comb begin
    rowBits = glyphRowBits(charHold, strobe.tag.glyphRow);
    pixOn   = rowBits[3'd7 - strobe.tag.glyphCol];
    if (!strobe.tag.visible)
      colourNext = 8'h00;
    else if (strobe.tag.mode16)
      colourNext = pixOn ? {4'h0, attrHold[3:0]} : {4'h0, attrHold[7:4]};
    else
      colourNext = pixOn ? attrHold : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixColour <= '0;
      pixActive <= 1'b0;
    end else begin
      pixColour <= colourNext;
      pixActive <= strobe.tag.visible;
    end
  end

endmodule

// File: rtl/txt_pixel_gen.sv
module txt_pixel_gen
  import txtgen_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int H_VIS  = 64,
  parameter int V_VIS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  input  logic              cfgMode16,
  input  logic              cfgDoubleW,
  input  logic              cfgDoubleH,
  input  logic [7:0]        vramData,
  output logic [ADDR_W-1:0] vramAddr,
  output logic [7:0]        pixColour,
  output logic              pixActive
);

  ctrlStrobe_t strobe;

  txtgen_ctrl #(
    .X_W(X_W), .Y_W(Y_W), .H_VIS(H_VIS), .V_VIS(V_VIS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY),
    .cfgMode16(cfgMode16), .cfgDoubleW(cfgDoubleW), .cfgDoubleH(cfgDoubleH),
    .vramAddr(vramAddr), .strobe(strobe)
  );

  txtgen_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vramData(vramData),
    .pixColour(pixColour), .pixActive(pixActive)
  );

endmodule

// File: rtl/txtgen_checker.sv
module txtgen_checker #(
  parameter int X_W   = 10,
  parameter int Y_W   = 10,
  parameter int H_VIS = 64,
  parameter int V_VIS = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic [X_W-1:0] pixX,
  input logic [Y_W-1:0] pixY,
  input logic           cfgMode16,
  input logic           cfgDoubleW,
  input logic           addrLsb,
  input logic [7:0]     pixColour,
  input logic           pixActive
);

  logic [2:0] warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  a_r1_idle_black: assert property (@(posedge clk) disable iff (!rstN)
    !pixActive |-> (pixColour == 8'h00));

  a_r1_active_window: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd4 && pixActive) |->
      (($past(pixX, 4) < X_W'(H_VIS)) && ($past(pixY, 4) < Y_W'(V_VIS))));

  a_r2_fetch_phase: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd1) |-> (addrLsb == $past(pixX[0])));

  a_r7_nibble_only: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd4 && pixActive && $past(cfgMode16, 4)) |-> (pixColour[7:4] == 4'h0));

  a_r8_pair_equal: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd5 && pixActive && $past(pixActive) &&
     $past(cfgDoubleW, 4) && $past(cfgDoubleW, 5) &&
     ($past(cfgMode16, 4) == $past(cfgMode16, 5)) &&
     $past(pixX[0], 4) &&
     ($past(pixX, 4) == $past(pixX, 5) + X_W'(1)) &&
     ($past(pixY, 4) == $past(pixY, 5)))
    |-> (pixColour == $past(pixColour)));

endmodule

bind txt_pixel_gen txtgen_checker #(
  .X_W(X_W), .Y_W(Y_W), .H_VIS(H_VIS), .V_VIS(V_VIS)
) u_txtgen_checker (
  .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY),
  .cfgMode16(cfgMode16), .cfgDoubleW(cfgDoubleW), .addrLsb(vramAddr[0]),
  .pixColour(pixColour), .pixActive(pixActive)
);

// File: tb/test_txt_pixel_gen.sv
module test_txt_pixel_gen;

  localparam int X_W    = 10;
  localparam int Y_W    = 10;
  localparam int H_VIS  = 64;
  localparam int V_VIS  = 32;
  localparam int ADDR_W = 12;
  localparam int MEM_SZ = 1 << ADDR_W;
  localparam int H_TOT  = 80;
  localparam int V_TOT  = 40;
  localparam int LAT    = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [X_W-1:0]    pixX = '0;
  logic [Y_W-1:0]    pixY = '0;
  logic              cfgMode16 = 1'b0;
  logic              cfgDoubleW = 1'b0;
  logic              cfgDoubleH = 1'b0;
  logic [7:0]        vramData;
  logic [ADDR_W-1:0] vramAddr;
  logic [7:0]        pixColour;
  logic              pixActive;

  logic [7:0] mem [MEM_SZ];
  // R4: memory answers combinationally to the presented address
  assign vramData = mem[vramAddr];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [8:0]        expHist [8];
  string             reqHist [8];
  logic [ADDR_W-1:0] addrHist [8];
  logic              addrOk [8];

  always #5 clk = ~clk;

  txt_pixel_gen #(
    .X_W(X_W), .Y_W(Y_W), .H_VIS(H_VIS), .V_VIS(V_VIS), .ADDR_W(ADDR_W)
  ) i_txt_pixel_gen (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY),
    .cfgMode16(cfgMode16), .cfgDoubleW(cfgDoubleW), .cfgDoubleH(cfgDoubleH),
    .vramData(vramData), .vramAddr(vramAddr),
    .pixColour(pixColour), .pixActive(pixActive)
  );

  function automatic int cellOf(int x, int y, logic dw, logic dh);
    int cw = dw ? 16 : 8;
    int ch = dh ? 16 : 8;
    return (y / ch) * (H_VIS / cw) + (x / cw);  // R3
  endfunction

  // Expected {active, colour}; R5 font, R6/R7 colour, R8/R9 scaling
  function automatic logic [8:0] expPix(int x, int y, logic m16, logic dw, logic dh);
    int cw = dw ? 16 : 8;
    int ch = dh ? 16 : 8;
    int gc, gr, idx;
    logic [7:0] a, c, g, col;
    logic on;
    if (x >= H_VIS || y >= V_VIS) return 9'h000;
    gc  = (x % cw) / (cw / 8);
    gr  = (y % ch) / (ch / 8);
    idx = cellOf(x, y, dw, dh);
    a = mem[(2 * idx) % MEM_SZ];
    c = mem[(2 * idx + 1) % MEM_SZ];
    g = c;
    for (int k = 0; k < gr; k++) g = {g[6:0], g[7]};
    on = g[7 - gc];
    if (m16) col = on ? {4'h0, a[3:0]} : {4'h0, a[7:4]};
    else     col = on ? a : 8'h00;
    return {1'b1, col};
  endfunction

  function automatic string reqName(logic vis, logic m16, logic dw, logic dh);
    if (!vis)          return "R1";
    if (dw || dh)      return (dw && dh) ? "R10" : (dw ? "R8" : "R9");
    return m16 ? "R7" : "R6";
  endfunction

  task automatic fillMem(int kind);
    for (int i = 0; i < MEM_SZ; i++) begin
      if (kind == 0)        mem[i] = 8'($urandom);
      else if (i % 2 == 0)  mem[i] = 8'($urandom);
      else                  mem[i] = ((i / 2) % 2 == 0) ? 8'hFF : 8'h00;
    end
  endtask

  // One clock: check results due now (R12 latency), then drive the next position.
  task automatic step(int x, int y);
    logic [8:0] e;
    @(negedge clk);
    if (cyc >= LAT) begin
      e = expHist[(cyc - LAT) % 8];
      checks++;
      if ({pixActive, pixColour} != e) begin
        fails++;
        $display("FAIL %s (R12 latency) cyc %0d: actual act=%0b col=%02h expected act=%0b col=%02h",
                 reqHist[(cyc - LAT) % 8], cyc, pixActive, pixColour, e[8], e[7:0]);
      end
    end
    if (cyc >= 1 && addrOk[(cyc - 1) % 8]) begin
      checks++;
      if (vramAddr != addrHist[(cyc - 1) % 8]) begin
        fails++;
        $display("FAIL R2 (R3 cell index) cyc %0d: actual addr=%0h expected addr=%0h",
                 cyc, vramAddr, addrHist[(cyc - 1) % 8]);
      end
    end
    pixX = X_W'(x);
    pixY = Y_W'(y);
    e = expPix(x, y, cfgMode16, cfgDoubleW, cfgDoubleH);
    expHist[cyc % 8] = e;
    reqHist[cyc % 8] = reqName(e[8], cfgMode16, cfgDoubleW, cfgDoubleH);
    addrOk[cyc % 8]  = e[8];
    addrHist[cyc % 8] = ADDR_W'(2 * cellOf(x, y, cfgDoubleW, cfgDoubleH) + (x % 2));
    cyc++;
  endtask

  task automatic runFrame(logic m16, logic dw, logic dh, int kind);
    fillMem(kind);
    cfgMode16  = m16;
    cfgDoubleW = dw;
    cfgDoubleH = dh;
    for (int y = 0; y < V_TOT; y++)
      for (int x = 0; x < H_TOT; x++)
        step(x, y);
  endtask

  task automatic checkReset(string when);
    checks++;
    if (pixActive !== 1'b0 || pixColour !== 8'h00 || vramAddr !== '0) begin
      fails++;
      $display("FAIL R11 %s: actual act=%0b col=%02h addr=%0h expected all zero",
               when, pixActive, pixColour, vramAddr);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd4711);
    fillMem(0);
    repeat (3) @(negedge clk);
    checkReset("at start");
    rstN = 1'b1;
    // Directed: every configuration combination (R10), one frame each
    for (int i = 0; i < 8; i++)
      runFrame(i[0], i[1], i[2], i % 2);
    // Random frames
    for (int i = 0; i < 4; i++) begin
      r = $urandom;
      runFrame(r[0], r[1], r[2], int'(r[3]));
    end
    // Reset in the middle of visible output
    cfgMode16 = 1'b0; cfgDoubleW = 1'b0; cfgDoubleH = 1'b0;
    for (int x = 0; x < 20; x++) step(x, 0);
    #2 rstN = 1'b0;
    @(negedge clk);
    checkReset("mid-line");
    summary();
  end

endmodule